// File: doc/BRIEF.md
# CAN Receive Acceptance Filter

This block decides which receive mailbox should take an incoming CAN frame. It holds a set of message objects. Each object stores a header tag (identifier, remote-request bit, reserved bit and IDE copy), a per-bit compare mask, a format choice (11-bit standard or 29-bit extended identifier), an enable bit and a direction bit. A header from the protocol engine arrives together with a one-cycle strobe. Every object checks it in parallel, and a fixed priority picks one winner. One clock later the block reports the winner's index and a hit flag. On that same edge it copies the received header into the winner's tag, so the tag then records what was actually accepted.

Objects are loaded one at a time through a configuration write port. Their tags can be read at any time through a combinational read port. Identifiers are left-aligned: a standard 11-bit identifier sits in bits 28..18 of every 29-bit identifier field, whether that field is on the frame input, the tag or the mask.

Top module: `can_accept_filter`

## Requirements
- R1: After reset every object is disabled with tag, mask and format cleared, `hit` is 0 and `hit_idx` is 0.
- R2: When `frm_valid` is 1 at a rising edge and at least one enabled receive object matches, `hit` is 1 and `hit_idx` holds the winner's index for exactly the following cycle. A match means that every compared bit of identifier, RTR and reserved bit equals the tag, and that the frame IDE equals the object format (1 for extended).
- R3: A mask bit of 0 (identifier bit, `cfg_mrtr`, `cfg_mrb`, `cfg_mide`) removes that position from the comparison. A mask bit of 1 makes the position compared.
- R4: An object with `cfg_en`=0, or with `cfg_rx`=0 (configured for transmit), never hits.
- R5: When several objects match the same frame, the lowest-numbered one wins, and only that object's tag is updated.
- R6: A standard-format object (`cfg_ext`=0) compares only identifier bits 28..18. Frame identifier bits 17..0 do not affect its result.
- R7: A frame whose IDE differs from the object's format is rejected when the IDE mask bit is 1 and accepted when it is 0, provided the other compared bits match.
- R8: On a hit, the winner's tag RTR, reserved and IDE bits take the received values. Its identifier takes all 29 received bits if the object is extended, and only bits 28..18 if it is standard, with bits 17..0 kept. Tags of all other objects are unchanged.
- R9: A cycle with `frm_valid`=0 gives `hit`=0 on the next cycle and leaves every tag unchanged.
- R10: A configuration write replaces the indexed object's tag, mask, format, enable and direction at the next edge. The tag IDE copy is loaded from `cfg_ext`. The read port then returns the written tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IDX_W (4) | Object to configure |
| cfg_id | input | 29 | Tag identifier |
| cfg_rtr | input | 1 | Tag remote-request bit |
| cfg_rb | input | 1 | Tag reserved bit |
| cfg_ext | input | 1 | Format: 1 extended, 0 standard |
| cfg_mid | input | 29 | Identifier compare mask |
| cfg_mrtr | input | 1 | RTR compare mask |
| cfg_mrb | input | 1 | Reserved-bit compare mask |
| cfg_mide | input | 1 | IDE compare mask |
| cfg_en | input | 1 | Object enable |
| cfg_rx | input | 1 | 1 receive, 0 transmit |
| frm_valid | input | 1 | Received header strobe |
| frm_id | input | 29 | Received identifier (standard in bits 28..18) |
| frm_rtr | input | 1 | Received RTR bit |
| frm_rb | input | 1 | Received reserved bit |
| frm_ide | input | 1 | Received IDE bit |
| rd_idx | input | IDX_W (4) | Object whose tag is read |
| rd_id | output | 29 | Tag identifier of `rd_idx` |
| rd_rtr | output | 1 | Tag RTR of `rd_idx` |
| rd_rb | output | 1 | Tag reserved bit of `rd_idx` |
| rd_ide | output | 1 | Tag IDE of `rd_idx` |
| hit | output | 1 | Frame accepted (one-cycle pulse) |
| hit_idx | output | IDX_W (4) | Winning object, 0 when no hit |

## Verification
The bench builds the filter with four objects. This makes every enable/direction combination across all objects, 256 patterns in total, cheap to sweep, so the lowest-index priority is checked against every possible set of competing matches. With four objects the bench can also walk a single masked or unmasked bit through all 29 identifier positions plus RTR and reserved, and cover all eight combinations of format, frame IDE and IDE mask. A long run of frames placed near the stored tags then tests the write-back. Because write-back keeps changing the tags, that run checks the accumulated tag history and not only isolated lookups.

// File: rtl/can_filt_pkg.sv
package can_filt_pkg;
    localparam int ID_W  = 29;
    localparam int STD_W = 11;
    localparam int LOW_W = ID_W - STD_W;

    typedef struct packed {
        logic [ID_W-1:0] id;
        logic            rtr;
        logic            rb;
        logic            ide;
    } hdr_t;

    typedef struct packed {
        hdr_t tag;
        hdr_t mask;
        logic ext;
        logic en;
        logic rx;
    } obj_t;
endpackage

// File: rtl/can_filt_obj.sv
module can_filt_obj
    import can_filt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_load,
    input  obj_t cfg_val,
    input  logic win,
    input  hdr_t frm,
    output logic match,
    output obj_t st
);
    obj_t st_d, st_q;
    hdr_t ref_h, cmp_m, diff;

    always_comb begin
        ref_h     = st_q.tag;
        ref_h.ide = st_q.ext;
        cmp_m     = st_q.mask;
        if (!st_q.ext) cmp_m.id[LOW_W-1:0] = '0;
        diff  = (ref_h ^ frm) & cmp_m;
        match = st_q.en && st_q.rx && (diff == '0);

        st_d = st_q;
        if (cfg_load) begin
            st_d = cfg_val;
        end else if (win) begin
            st_d.tag.rtr = frm.rtr;
            st_d.tag.rb  = frm.rb;
            st_d.tag.ide = frm.ide;
            if (st_q.ext) st_d.tag.id = frm.id;
            else          st_d.tag.id[ID_W-1:LOW_W] = frm.id[ID_W-1:LOW_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st = st_q;

    // R2: the arbiter may only grant an object that matches
    assert_win_matches_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win |-> match);

    // R9: without a grant or a load the object keeps its state
    assert_idle_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !win) |=> $stable(st_q));

    // R6: standard objects never alter their low identifier bits on a hit
    assert_std_low_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_load && !st_q.ext) |=> $stable(st_q.tag.id[LOW_W-1:0]));
endmodule

// File: rtl/can_filt_prio.sv
module can_filt_prio #(
    parameter int N     = 15,
    parameter int IDX_W = 4
) (
    input  logic [N-1:0]     req,
    output logic [N-1:0]     grant,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IDX_W'(i);
            end
        end
        any = |req;
    end
endmodule

// File: rtl/can_accept_filter.sv
module can_accept_filter
    import can_filt_pkg::*;
#(
    parameter int NUM_OBJ = 15,
    parameter int IDX_W   = (NUM_OBJ > 1) ? $clog2(NUM_OBJ) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [ID_W-1:0]  cfg_id,
    input  logic             cfg_rtr,
    input  logic             cfg_rb,
    input  logic             cfg_ext,
    input  logic [ID_W-1:0]  cfg_mid,
    input  logic             cfg_mrtr,
    input  logic             cfg_mrb,
    input  logic             cfg_mide,
    input  logic             cfg_en,
    input  logic             cfg_rx,
    input  logic             frm_valid,
    input  logic [ID_W-1:0]  frm_id,
    input  logic             frm_rtr,
    input  logic             frm_rb,
    input  logic             frm_ide,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_id,
    output logic             rd_rtr,
    output logic             rd_rb,
    output logic             rd_ide,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx
);
    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } out_t;

    obj_t             cfg_obj;
    hdr_t             frm;
    obj_t             obj_st [NUM_OBJ];
    logic [NUM_OBJ-1:0] req, grant;
    logic [IDX_W-1:0] win_idx;
    logic             any_req;
    out_t             out_d, out_q;

    always_comb begin
        cfg_obj.tag.id   = cfg_id;
        cfg_obj.tag.rtr  = cfg_rtr;
        cfg_obj.tag.rb   = cfg_rb;
        cfg_obj.tag.ide  = cfg_ext;
        cfg_obj.mask.id  = cfg_mid;
        cfg_obj.mask.rtr = cfg_mrtr;
        cfg_obj.mask.rb  = cfg_mrb;
        cfg_obj.mask.ide = cfg_mide;
        cfg_obj.ext      = cfg_ext;
        cfg_obj.en       = cfg_en;
        cfg_obj.rx       = cfg_rx;
        frm.id  = frm_id;
        frm.rtr = frm_rtr;
        frm.rb  = frm_rb;
        frm.ide = frm_ide;
    end

    for (genvar g = 0; g < NUM_OBJ; g++) begin : g_obj
        logic load_g, win_g;
        assign load_g = cfg_we && (cfg_idx == IDX_W'(g));
        assign win_g  = frm_valid && grant[g];
        can_filt_obj u_obj (
            .clk      (clk),
            .rst_n    (rst_n),
            .cfg_load (load_g),
            .cfg_val  (cfg_obj),
            .win      (win_g),
            .frm      (frm),
            .match    (req[g]),
            .st       (obj_st[g])
        );
    end

    can_filt_prio #(.N(NUM_OBJ), .IDX_W(IDX_W)) u_prio (
        .req   (req),
        .grant (grant),
        .idx   (win_idx),
        .any   (any_req)
    );

    always_comb begin
        out_d.hit = frm_valid && any_req;
        out_d.idx = out_d.hit ? win_idx : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    always_comb begin
        rd_id  = '0;
        rd_rtr = 1'b0;
        rd_rb  = 1'b0;
        rd_ide = 1'b0;
        for (int i = 0; i < NUM_OBJ; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_id  = obj_st[i].tag.id;
                rd_rtr = obj_st[i].tag.rtr;
                rd_rb  = obj_st[i].tag.rb;
                rd_ide = obj_st[i].tag.ide;
            end
        end
    end

    assign hit     = out_q.hit;
    assign hit_idx = out_q.idx;

    // R5: at most one object is chosen
    assert_single_winner_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: no lower-numbered requester exists below the chosen one
    assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> ((req & (grant - NUM_OBJ'(1))) == '0));

    // R9: no strobe, no hit on the next cycle
    assert_no_strobe_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_valid |=> !hit);

    // R2: a reported index always names an existing object
    assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (32'(hit_idx) < NUM_OBJ));
endmodule

// File: tb/sim_can_accept_filter.sv
`timescale 1ns/1ps
module sim_can_accept_filter;
    localparam int NO = 4;
    localparam int IW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 0; logic [IW-1:0] cfg_idx = 0;
    logic [28:0] cfg_id = 0, cfg_mid = 0;
    logic cfg_rtr = 0, cfg_rb = 0, cfg_ext = 0, cfg_mrtr = 0, cfg_mrb = 0, cfg_mide = 0, cfg_en = 0, cfg_rx = 0;
    logic frm_valid = 0; logic [28:0] frm_id = 0; logic frm_rtr = 0, frm_rb = 0, frm_ide = 0;
    logic [IW-1:0] rd_idx = 0;
    logic [28:0] rd_id; logic rd_rtr, rd_rb, rd_ide, hit; logic [IW-1:0] hit_idx;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [28:0] m_id [NO]; logic m_rtr [NO]; logic m_rb [NO]; logic m_ide [NO];
    logic [28:0] m_mid [NO]; logic m_mrtr [NO]; logic m_mrb [NO]; logic m_mide [NO];
    logic m_ext [NO]; logic m_en [NO]; logic m_rx [NO];

    can_accept_filter #(.NUM_OBJ(NO)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_id(cfg_id),
        .cfg_rtr(cfg_rtr), .cfg_rb(cfg_rb), .cfg_ext(cfg_ext), .cfg_mid(cfg_mid),
        .cfg_mrtr(cfg_mrtr), .cfg_mrb(cfg_mrb), .cfg_mide(cfg_mide), .cfg_en(cfg_en),
        .cfg_rx(cfg_rx), .frm_valid(frm_valid), .frm_id(frm_id), .frm_rtr(frm_rtr),
        .frm_rb(frm_rb), .frm_ide(frm_ide), .rd_idx(rd_idx), .rd_id(rd_id),
        .rd_rtr(rd_rtr), .rd_rb(rd_rb), .rd_ide(rd_ide), .hit(hit), .hit_idx(hit_idx));

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cfg(input int o, input logic [28:0] id, input logic rtr, input logic rb,
                       input logic ext, input logic [28:0] mid, input logic mrtr, input logic mrb,
                       input logic mide, input logic en, input logic rx);
        cfg_we = 1; cfg_idx = IW'(o); cfg_id = id; cfg_rtr = rtr; cfg_rb = rb; cfg_ext = ext;
        cfg_mid = mid; cfg_mrtr = mrtr; cfg_mrb = mrb; cfg_mide = mide; cfg_en = en; cfg_rx = rx;
        @(negedge clk);
        cfg_we = 0;
        m_id[o] = id; m_rtr[o] = rtr; m_rb[o] = rb; m_ide[o] = ext; m_mid[o] = mid;
        m_mrtr[o] = mrtr; m_mrb[o] = mrb; m_mide[o] = mide; m_ext[o] = ext; m_en[o] = en; m_rx[o] = rx;
    endtask

    task automatic check_tags(input string req);
        for (int o = 0; o < NO; o++) begin
            rd_idx = IW'(o);
            #0.1;
            check(rd_id == m_id[o], req, 32'(rd_id), 32'(m_id[o]));
            check({rd_rtr, rd_rb, rd_ide} == {m_rtr[o], m_rb[o], m_ide[o]}, req,
                  32'({rd_rtr, rd_rb, rd_ide}), 32'({m_rtr[o], m_rb[o], m_ide[o]}));
        end
    endtask

    function automatic bit accepts(input int o, input logic [28:0] id, input logic rtr,
                                   input logic rb, input logic ide);
        logic [28:0] cm;
        if (!(m_en[o] && m_rx[o])) return 0;
        cm = m_ext[o] ? m_mid[o] : (m_mid[o] & {11'h7FF, 18'h0});
        if (((m_id[o] ^ id) & cm) != 0) return 0;
        if (m_mrtr[o] && (m_rtr[o] != rtr)) return 0;
        if (m_mrb[o] && (m_rb[o] != rb)) return 0;
        if (m_mide[o] && (m_ext[o] != ide)) return 0;
        return 1;
    endfunction

    task automatic send(input logic [28:0] id, input logic rtr, input logic rb, input logic ide,
                        input string req);
        int w = -1;
        for (int o = NO - 1; o >= 0; o--) if (accepts(o, id, rtr, rb, ide)) w = o;
        frm_valid = 1; frm_id = id; frm_rtr = rtr; frm_rb = rb; frm_ide = ide;
        @(negedge clk);
        frm_valid = 0;
        check(hit == (w >= 0), req, 32'(hit), 32'(w >= 0));
        check(hit_idx == ((w >= 0) ? IW'(w) : IW'(0)), req, 32'(hit_idx), (w >= 0) ? 32'(w) : 0);
        if (w >= 0) begin
            m_rtr[w] = rtr; m_rb[w] = rb; m_ide[w] = ide;
            if (m_ext[w]) m_id[w] = id;
            else          m_id[w] = {id[28:18], m_id[w][17:0]};
        end
        check_tags({req, "/R8"});
    endtask

    initial begin
        #(4.0 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [28:0] base;
        for (int o = 0; o < NO; o++) begin
            m_id[o] = 0; m_rtr[o] = 0; m_rb[o] = 0; m_ide[o] = 0; m_mid[o] = 0; m_mrtr[o] = 0;
            m_mrb[o] = 0; m_mide[o] = 0; m_ext[o] = 0; m_en[o] = 0; m_rx[o] = 0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        check(hit == 0, "R1", 32'(hit), 0);
        check(hit_idx == 0, "R1", 32'(hit_idx), 0);
        check_tags("R1");
        send(29'h0, 0, 0, 0, "R1");

        // R10: configuration then read back
        cfg(2, 29'h15A5A5A5, 1, 0, 1, '1, 1, 1, 1, 1, 1);
        check_tags("R10");
        cfg(2, 29'h0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R4/R5: every enable and direction pattern, identical tags
        for (int en = 0; en < 16; en++) begin
            for (int rx = 0; rx < 16; rx++) begin
                for (int o = 0; o < NO; o++)
                    cfg(o, 29'h0ABCDE12, 0, 0, 1, '1, 1, 1, 1, en[o], rx[o]);
                send(29'h0ABCDE12, 0, 0, 1, "R4/R5");
            end
        end

        // R3: single bit masked or compared at every identifier position
        for (int o = 1; o < NO; o++) cfg(o, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        for (int b = 0; b < 31; b++) begin
            for (int m = 0; m < 2; m++) begin
                logic [28:0] mk;
                logic [28:0] fid;
                mk = '1;
                if (b < 29) mk[b] = m[0];
                cfg(0, 29'h12345678, 0, 1, 1, mk, (b == 29) ? m[0] : 1'b1,
                    (b == 30) ? m[0] : 1'b1, 1, 1, 1);
                fid = 29'h12345678;
                if (b < 29) fid[b] = ~fid[b];
                send(fid, (b == 29), (b == 30) ? 1'b0 : 1'b1, 1, "R3");
            end
        end

        // R6: standard object ignores low identifier bits
        for (int k = 0; k < 8; k++) begin
            cfg(1, {11'h5A3, 18'h2AAAA}, 1, 0, 0, '1, 1, 1, 1, 1, 1);
            send({11'h5A3, 18'(k * 29'h4F1B)}, 1, 0, 0, "R6");
            send({11'h5A2, 18'h2AAAA}, 1, 0, 0, "R6");
        end
        cfg(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);

        // R7: format, frame IDE and IDE mask
        for (int c = 0; c < 8; c++) begin
            cfg(0, 29'h1F000000, 0, 0, c[0], '1, 1, 1, c[2], 1, 1);
            send(29'h1F000000, 0, 0, c[1], "R7");
        end

        // R9: idle cycles change nothing
        cfg(3, 29'h00000777, 0, 0, 1, '1, 1, 1, 1, 1, 1);
        frm_id = 29'h00000777; frm_ide = 1; frm_valid = 0;
        @(negedge clk);
        check(hit == 0, "R9", 32'(hit), 0);
        check_tags("R9");

        // R2/R8: mixed frames near the stored tags
        for (int o = 0; o < NO; o++) begin
            logic [28:0] r;
            r = 29'($urandom);
            cfg(o, r, 0, 0, o[0], 29'h1FFF00FF | (29'h1 << (o + 8)), o[1], 1, 1, 1, 1);
        end
        for (int t = 0; t < 400; t++) begin
            int o;
            logic [28:0] fid;
            o = $urandom_range(0, NO - 1);
            base = m_id[o];
            fid = base ^ ((29'($urandom) & 29'($urandom) & 29'($urandom)));
            send(fid, $urandom_range(0, 1), ($urandom_range(0, 7) != 0) ? m_rb[o] : ~m_rb[o],
                 ($urandom_range(0, 7) != 0) ? m_ext[o] : ~m_ext[o], "R2");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule